// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the arithmetic unit of an 8-bit processor core. Each operation takes two operand bytes, a 4-bit operation code and the current status flags. It returns a result byte, a write enable for that byte and the updated flags. Addition, subtraction, compare, the bitwise operations, shifts, rotates, nibble exchange, increment and decrement are combinational. Their results are valid in the same cycle that `op_valid` is high.

Multiply and divide run one iteration per clock. A multiply or divide is accepted in the cycle that `op_valid` is high. The block then shows `busy` for DW cycles and raises `done` for exactly one cycle. During that `done` cycle it presents the low byte on `res` and the high byte on `res_hi`, with both write enables set. For multiply the low byte goes to the accumulator and the high byte to the Y register. For divide the quotient is on `res` and the remainder on `res_hi`. Operand fetch and register storage stay with the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: The flag vector is {N,V,H,Z,C}, with N at bit 4 and C at bit 0. Code 0 is add with carry, r = a + b + C. C is set when the 9-bit sum exceeds 0xFF. V is bit 7 of (a^r)&(b^r). H is bit 4 of a^b^r. N is r[7], Z is (r==0), and the result is written.
- R2: Code 1 is subtract with carry, r = a - b - (1-C). C is set when no borrow occurs. V is bit 7 of (a^r)&(a^b). H is the inverse of bit 4 of a^b^r. N and Z come from r, and the result is written.
- R3: Code 2 is compare, a - b with no carry-in. It drives `res_we` low, sets N, Z and C as subtraction does, and passes V and H through unchanged.
- R4: Codes 3 (AND), 4 (OR), 5 (XOR), 11 (a+1) and 12 (a-1) write the result and set only N and Z. V, H and C pass through.
- R5: Code 6 shifts a left and loads C from a[7]. Code 7 shifts a right and loads C from a[0]. Code 8 rotates left with old C into bit 0 and new C from a[7]. Code 9 rotates right with old C into bit 7 and new C from a[0]. N and Z come from the result, V and H pass through, and the result is written.
- R6: Code 10 swaps the two nibbles of a, sets N and Z from the swapped byte, and keeps V, H and C.
- R7: Code 13 multiplies a by b. At `done`, `res` holds product bits 7:0 and `res_hi` holds bits 15:8. N is product bit 15 and Z is (product==0). V, H and C keep their values from the start cycle.
- R8: Code 14 divides a by b. At `done`, `res` holds the quotient and `res_hi` the remainder. N and Z come from the quotient, V is cleared, and H and C are kept.
- R9: A divide by zero completes on the normal schedule with quotient 0xFF, remainder equal to a, and V set.
- R10: When a multiply or divide is accepted in cycle 0, `busy` is high in cycles 1 to DW and `done` is high only in cycle DW+1. In cycle 0, and in every cycle except the `done` cycle, `res_we` and `res_hi_we` stay low for these codes.
- R11: While `busy` or `done` is high, `op_valid` is ignored and does not alter the pending result. Code 15 writes nothing and passes all flags through.
- R12: After reset `busy` and `done` are low. With `op_valid` low, no write enable is asserted and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector |
| opa | input | DW | First operand (dividend, multiplicand) |
| opb | input | DW | Second operand (divisor, multiplier) |
| flags_in | input | 5 | Current flags {N,V,H,Z,C} |
| res | output | DW | Result byte (low product byte or quotient for multiply/divide) |
| res_we | output | 1 | Result byte is to be written |
| res_hi | output | DW | High product byte or remainder |
| res_hi_we | output | 1 | High byte is to be written |
| flags_out | output | 5 | Updated flags {N,V,H,Z,C} |
| busy | output | 1 | Multiply/divide iterating |
| done | output | 1 | Multiply/divide result valid this cycle |

## Verification
Single-cycle results are combinational from the inputs. The bench drives each operation just after a rising edge and samples at the following falling edge, before the edge that would retire it. For multiply and divide, the cycle carrying `op_valid` is counted as cycle 0. The bench samples `busy` at the falling edge of each of cycles 1 to DW and expects `done` with the full result at the falling edge of cycle DW+1. One run injects a second operation in the middle of the busy window to show that it is dropped.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADC  = 4'd0,
    OP_SBC  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_ASL  = 4'd6,
    OP_LSR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_XCN  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_MUL  = 4'd13,
    OP_DIV  = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic h;
    logic z;
    logic c;
  } alu_flags_t;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_RUN  = 2'd1,
    MD_DONE = 2'd2
  } md_state_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  alu_flags_t       fin,
  output logic [DW-1:0]    r,
  output logic             wr,
  output alu_flags_t       fout
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2;

  // One adder serves all three codes; subtraction adds the inverted operand.
  function automatic logic [DW:0] add_cin(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic cin);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
  endfunction

  logic          is_sub;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  always_comb begin
    is_sub = (op == OP_SBC) || (op == OP_CMP);
    b_eff  = is_sub ? ~b : b;
    cin    = (op == OP_CMP) ? 1'b1 : fin.c;
    sum    = add_cin(a, b_eff, cin);
  end

  always_comb begin
    r    = sum[DW-1:0];
    wr   = (op != OP_CMP);
    fout = fin;
    fout.c = sum[DW];
    fout.n = r[MSB];
    fout.z = (r == '0);
    if (op != OP_CMP) begin
      // a ^ b_eff ^ r gives carry-in to bit HB; inverted operand yields no-borrow
      fout.h = a[HB] ^ b_eff[HB] ^ r[HB];
      if (is_sub) fout.v = (a[MSB] ^ r[MSB]) & (a[MSB] ^ b[MSB]);
      else        fout.v = (a[MSB] ^ r[MSB]) & (b[MSB] ^ r[MSB]);
    end
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  alu_flags_t       fin,
  output logic [DW-1:0]    r,
  output alu_flags_t       fout
);
  localparam int MSB = DW - 1;
  localparam int HB  = DW / 2;

  function automatic logic [DW-1:0] swap_halves(input logic [DW-1:0] x);
    return {x[HB-1:0], x[DW-1:HB]};
  endfunction

  always_comb begin
    r    = a;
    fout = fin;
    unique case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_INC: r = a + DW'(1);
      OP_DEC: r = a - DW'(1);
      OP_ASL: begin r = {a[MSB-1:0], 1'b0};  fout.c = a[MSB]; end
      OP_LSR: begin r = {1'b0, a[MSB:1]};    fout.c = a[0];   end
      OP_ROL: begin r = {a[MSB-1:0], fin.c}; fout.c = a[MSB]; end
      OP_ROR: begin r = {fin.c, a[MSB:1]};   fout.c = a[0];   end
      OP_XCN: r = swap_halves(a);
      default: r = a;
    endcase
    fout.n = r[MSB];
    fout.z = (r == '0);
  end

endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_div,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          busy,
  output logic          done,
  output logic          is_div,
  output logic          div_zero,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  md_state_e     state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hi_q, lo_q, mc_q;
  logic          div_q, dz_q;

  // shift-add multiply step: {hi,lo} >> 1 after optional add into hi
  logic [DW:0]   msum;
  logic [DW-1:0] mhi, mlo;
  // restoring divide step: remainder in hi, quotient shifts into lo
  logic [DW:0]   dsh, ddf;
  logic          dge;
  logic [DW-1:0] dhi, dlo;

  always_comb begin
    msum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    mhi  = msum[DW:1];
    mlo  = {msum[0], lo_q[DW-1:1]};
    dsh  = {hi_q, lo_q[DW-1]};
    ddf  = dsh - {1'b0, mc_q};
    dge  = (dsh >= {1'b0, mc_q});
    dhi  = dge ? ddf[DW-1:0] : dsh[DW-1:0];
    dlo  = {lo_q[DW-2:0], dge};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MD_IDLE;
      cnt   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      mc_q  <= '0;
      div_q <= 1'b0;
      dz_q  <= 1'b0;
    end else begin
      unique case (state)
        MD_IDLE: if (start) begin
          hi_q  <= '0;
          lo_q  <= start_div ? a : b;
          mc_q  <= start_div ? b : a;
          div_q <= start_div;
          dz_q  <= start_div && (b == '0);
          cnt   <= '0;
          state <= MD_RUN;
        end
        MD_RUN: begin
          hi_q <= div_q ? dhi : mhi;
          lo_q <= div_q ? dlo : mlo;
          cnt  <= cnt + CW'(1);
          if (cnt == LAST) state <= MD_DONE;
        end
        MD_DONE: state <= MD_IDLE;
        default: state <= MD_IDLE;
      endcase
    end
  end

  assign busy     = (state == MD_RUN);
  assign done     = (state == MD_DONE);
  assign is_div   = div_q;
  assign div_zero = dz_q;
  assign lo       = lo_q;
  assign hi       = hi_q;

  // checker-side run-length counter, independent of cnt
  logic [CW:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_run_length_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == (CW+1)'(DW)));
  p_rem_below_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_q && !dz_q) |-> (hi_q < mc_q));
  p_div0_all_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_q && dz_q) |-> (lo_q == '1));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [4:0]    flags_in,
  output logic [DW-1:0] res,
  output logic          res_we,
  output logic [DW-1:0] res_hi,
  output logic          res_hi_we,
  output logic [4:0]    flags_out,
  output logic          busy,
  output logic          done
);
  localparam int MSB = DW - 1;

  alu_op_e    op;
  alu_flags_t fin;
  assign op  = alu_op_e'(op_code);
  assign fin = alu_flags_t'(flags_in);

  // named events for the assertions
  logic ev_idle, ev_accept, ev_start_md, ev_arith, ev_bitop;
  logic md_busy, md_done, md_is_div, md_dz;
  logic [DW-1:0] md_lo, md_hi;

  assign ev_idle     = !md_busy && !md_done;
  assign ev_accept   = op_valid && ev_idle;
  assign ev_arith    = ev_accept && (op inside {OP_ADC, OP_SBC, OP_CMP});
  assign ev_bitop    = ev_accept && (op inside {OP_AND, OP_OR, OP_XOR, OP_ASL, OP_LSR,
                                                OP_ROL, OP_ROR, OP_XCN, OP_INC, OP_DEC});
  assign ev_start_md = ev_accept && (op inside {OP_MUL, OP_DIV});

  logic [DW-1:0] as_r, bo_r;
  logic          as_wr;
  alu_flags_t    as_f, bo_f;

  alu8_addsub #(.DW(DW)) u_addsub (
    .op(op), .a(opa), .b(opb), .fin(fin), .r(as_r), .wr(as_wr), .fout(as_f)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op(op), .a(opa), .b(opb), .fin(fin), .r(bo_r), .fout(bo_f)
  );

  alu8_muldiv #(.DW(DW)) u_muldiv (
    .clk(clk), .rst_n(rst_n), .start(ev_start_md), .start_div(op == OP_DIV),
    .a(opa), .b(opb), .busy(md_busy), .done(md_done), .is_div(md_is_div),
    .div_zero(md_dz), .lo(md_lo), .hi(md_hi)
  );

  // flags held from the start cycle of a multiply or divide
  alu_flags_t md_fq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           md_fq <= '0;
    else if (ev_start_md) md_fq <= fin;
  end

  alu_flags_t md_f;
  always_comb begin
    md_f = md_fq;
    if (md_is_div) begin
      md_f.n = md_lo[MSB];
      md_f.z = (md_lo == '0);
      md_f.v = md_dz;
    end else begin
      md_f.n = md_hi[MSB];
      md_f.z = ({md_hi, md_lo} == '0);
    end
  end

  alu_flags_t fo;
  always_comb begin
    res       = '0;
    res_hi    = '0;
    res_we    = 1'b0;
    res_hi_we = 1'b0;
    fo        = fin;
    if (md_done) begin
      res       = md_lo;
      res_hi    = md_hi;
      res_we    = 1'b1;
      res_hi_we = 1'b1;
      fo        = md_f;
    end else if (ev_arith) begin
      res    = as_r;
      res_we = as_wr;
      fo     = as_f;
    end else if (ev_bitop) begin
      res    = bo_r;
      res_we = 1'b1;
      fo     = bo_f;
    end
  end

  assign flags_out = fo;
  assign busy      = md_busy;
  assign done      = md_done;

  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && op == OP_CMP) |-> (!res_we && flags_out[3:2] == flags_in[3:2]));
  p_logic_keeps_vhc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && op inside {OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC})
      |-> (flags_out[3:2] == flags_in[3:2] && flags_out[0] == flags_in[0]));
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_md |=> busy);
  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_no_write_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!res_we && !res_hi_we));
  p_div0_sets_v_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md_is_div && md_dz) |-> (flags_out[3] && res == '1));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !done) |-> (!res_we && !res_hi_we && flags_out == flags_in));

endmodule

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = 4'd15;
  logic [DW-1:0] opa = '0, opb = '0;
  logic [4:0]    flags_in = '0;
  logic [DW-1:0] res, res_hi;
  logic          res_we, res_hi_we, busy, done;
  logic [4:0]    flags_out;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  alu8_core #(.DW(DW)) u_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .flags_in(flags_in), .res(res), .res_we(res_we),
    .res_hi(res_hi), .res_hi_we(res_hi_we), .flags_out(flags_out),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model: returns {we, N,V,H,Z,C, r[7:0]}
  function automatic logic [13:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [4:0] f);
    int s;
    logic [7:0] r;
    logic n, v, h, z, c, we;
    {n, v, h, z, c} = f;
    we = 1'b1;
    r  = a;
    case (op)
      4'd0: begin
        s = int'(a) + int'(b) + (c ? 1 : 0);
        r = s[7:0]; c = (s > 255);
        v = ((a ^ r) & (b ^ r) & 8'h80) != 0;
        h = ((a ^ b ^ r) & 8'h10) != 0;
      end
      4'd1: begin
        s = int'(a) - int'(b) - (c ? 0 : 1);
        r = s[7:0]; c = (s >= 0);
        v = ((a ^ r) & (a ^ b) & 8'h80) != 0;
        h = ((a ^ b ^ r) & 8'h10) == 0;
      end
      4'd2: begin s = int'(a) - int'(b); r = s[7:0]; c = (s >= 0); we = 1'b0; end
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: begin r = a << 1; c = a[7]; end
      4'd7: begin r = a >> 1; c = a[0]; end
      4'd8: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; end
      4'd9: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; end
      4'd10: r = {a[3:0], a[7:4]};
      4'd11: r = a + 8'd1;
      4'd12: r = a - 8'd1;
      default: we = 1'b0;
    endcase
    if (op != 4'd15) begin n = r[7]; z = (r == 8'd0); end
    else r = 8'd0;
    return {we, n, v, h, z, c, r};
  endfunction

  // drive one combinational operation; sample at the falling edge of the same cycle
  task automatic t_single(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [4:0] f);
    logic [13:0] e;
    e = model(op, a, b, f);
    @(posedge clk); #2;
    op_valid = 1'b1; op_code = op; opa = a; opb = b; flags_in = f;
    @(negedge clk);
    check(req, "write enable", {31'd0, res_we}, {31'd0, e[13]});
    if (e[13]) check(req, "result", {24'd0, res}, {24'd0, e[7:0]});
    check(req, "flags", {27'd0, flags_out}, {27'd0, e[12:8]});
    @(posedge clk); #2;
    op_valid = 1'b0;
  endtask

  // multiply (13) or divide (14); optionally inject another op mid-run
  task automatic t_muldiv(input string req, input logic [3:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [4:0] f, input bit inject);
    logic [7:0] e_lo, e_hi;
    logic [4:0] e_f;
    logic [15:0] p;
    bit run_ok;
    e_f = f;
    if (op == 4'd13) begin
      p = 16'(a) * 16'(b);
      e_lo = p[7:0]; e_hi = p[15:8];
      e_f[4] = p[15]; e_f[1] = (p == 16'd0);
    end else begin
      e_lo = (b == 0) ? 8'hFF : 8'(a / b);
      e_hi = (b == 0) ? a : 8'(a % b);
      e_f[4] = e_lo[7]; e_f[1] = (e_lo == 8'd0); e_f[3] = (b == 0);
    end
    @(posedge clk); #2;
    op_valid = 1'b1; op_code = op; opa = a; opb = b; flags_in = f;
    @(negedge clk);
    check("R10", "no write in start cycle", {30'd0, res_we, res_hi_we}, 32'd0);
    run_ok = 1'b1;
    for (int k = 1; k <= DW; k++) begin
      @(posedge clk); #2;
      if (k == 2 && inject) begin
        op_valid = 1'b1; op_code = 4'd0; opa = 8'h11; opb = 8'h22; flags_in = 5'b00000;
      end else begin
        op_valid = 1'b0; flags_in = 5'b00000;
      end
      @(negedge clk);
      if (!(busy === 1'b1 && done === 1'b0 && res_we === 1'b0 && res_hi_we === 1'b0))
        run_ok = 1'b0;
    end
    check(inject ? "R11" : "R10", "busy window", {31'd0, run_ok}, 32'd1);
    @(posedge clk); #2;
    op_valid = 1'b0;
    @(negedge clk);
    check("R10", "done cycle", {29'd0, busy, done, res_we & res_hi_we}, 32'd3);
    check(req, "low byte", {24'd0, res}, {24'd0, e_lo});
    check(req, "high byte", {24'd0, res_hi}, {24'd0, e_hi});
    check(req, "flags", {27'd0, flags_out}, {27'd0, e_f});
    @(posedge clk); #2;
    @(negedge clk);
    check("R10", "done drops", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12", "busy/done in reset", {30'd0, busy, done}, 32'd0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    flags_in = 5'b10101;
    #1;
    check("R12", "idle write enables", {30'd0, res_we, res_hi_we}, 32'd0);
    check("R12", "idle flags pass", {27'd0, flags_out}, 32'd21);
  endtask

  initial begin
    #(20 * 100000);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    // R1 add with carry
    t_single("R1", 4'd0, 8'h7F, 8'h01, 5'b00000);
    t_single("R1", 4'd0, 8'hFF, 8'h01, 5'b00000);
    t_single("R1", 4'd0, 8'h10, 8'h20, 5'b00001);
    // R2 subtract with carry
    t_single("R2", 4'd1, 8'h50, 8'h10, 5'b00001);
    t_single("R2", 4'd1, 8'h00, 8'h01, 5'b00001);
    t_single("R2", 4'd1, 8'h80, 8'h01, 5'b00001);
    t_single("R2", 4'd1, 8'h05, 8'h05, 5'b00000);
    // R3 compare
    t_single("R3", 4'd2, 8'h42, 8'h42, 5'b01100);
    t_single("R3", 4'd2, 8'h10, 8'h42, 5'b01001);
    // R4 logic, increment, decrement
    t_single("R4", 4'd3, 8'hF0, 8'h3C, 5'b01101);
    t_single("R4", 4'd4, 8'h00, 8'h00, 5'b01101);
    t_single("R4", 4'd5, 8'hAA, 8'h55, 5'b00000);
    t_single("R4", 4'd11, 8'hFF, 8'h00, 5'b01001);
    t_single("R4", 4'd12, 8'h00, 8'h00, 5'b00100);
    // R5 shifts and rotates
    t_single("R5", 4'd6, 8'h81, 8'h00, 5'b01100);
    t_single("R5", 4'd7, 8'h01, 8'h00, 5'b00000);
    t_single("R5", 4'd8, 8'h80, 8'h00, 5'b00001);
    t_single("R5", 4'd9, 8'h02, 8'h00, 5'b00001);
    t_single("R5", 4'd9, 8'h01, 8'h00, 5'b00000);
    // R6 nibble exchange
    t_single("R6", 4'd10, 8'h3C, 8'h00, 5'b01101);
    t_single("R6", 4'd10, 8'h00, 8'h00, 5'b00000);
    // R11 reserved code
    t_single("R11", 4'd15, 8'h12, 8'h34, 5'b11011);
    // R7 multiply
    t_muldiv("R7", 4'd13, 8'hFF, 8'hFF, 5'b01101, 1'b0);
    t_muldiv("R7", 4'd13, 8'h00, 8'h55, 5'b00000, 1'b0);
    t_muldiv("R7", 4'd13, 8'h0C, 8'h0F, 5'b00101, 1'b1);
    // R8 divide
    t_muldiv("R8", 4'd14, 8'd200, 8'd7, 5'b01101, 1'b0);
    t_muldiv("R8", 4'd14, 8'd5, 8'd9, 5'b01000, 1'b0);
    // R9 divide by zero
    t_muldiv("R9", 4'd14, 8'h37, 8'h00, 5'b00101, 1'b1);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule